// File: doc/BRIEF.md
# Interrupt Enable and Sleep Controller

This controller sits beside a small 8-bit CPU core. It owns the global interrupt enable bit and the core's sleep state. The decoder tells it which instruction has just retired: disable, enable, return-from-handler or sleep. It also gives an instruction-completion strobe and the two 5-bit interrupt registers (enable mask and request flags). From these inputs the controller decides when an interrupt handler must be entered and which handler address to use. It also reports which request bit the handler acknowledges.

The enable instruction takes effect only once the instruction after it has retired. The return-from-handler instruction takes effect at its own completion. The sleep instruction has three outcomes:

- It sleeps and then services the interrupt that wakes it.
- It sleeps and then simply resumes, with no handler entered.
- It does not sleep at all, and it tells the fetch unit that the next opcode fetch must not advance the program counter. The byte after the sleep instruction is then read twice.

Top module: `irq_sleep_ctrl`

## Requirements
- R1: After reset, imeFlag, halted, fetchRepeat and svcStart are all 0.
- R2: A disable strobe at a completion cycle clears imeFlag from the next cycle on. A request pending at that same completion is not serviced.
- R3: An enable strobe leaves imeFlag unchanged at its own completion and sets it at the next completion. A disable strobe at that next completion cancels the pending enable. A request pending through the enable is serviced at the following completion and not before.
- R4: A return-from-handler strobe sets the enable at its own completion. A request pending then is serviced at that same completion.
- R5: Service starts at a completion cycle when the effective enable is 1 and (ieReg & ifReg) is non-zero. svcStart is then high for exactly the next cycle and imeFlag reads 0.
- R6: When svcStart is high, svcAck is one-hot at the lowest-numbered set bit i of (ieReg & ifReg), with bit i of svcAck matching bit i of ieReg/ifReg. svcVector equals 0x40 + 8*i.
- R7: No service starts while the enable is 0, nor while ifReg bits are set only where ieReg is 0.
- R8: Sleep with the enable set and nothing pending raises halted. halted stays high until a request is pending. On the cycle after that, halted is 0, svcStart is 1 and imeFlag is 0.
- R9: Sleep with the enable clear and nothing pending raises halted. Once a request is pending, halted drops without any service and the enable stays 0.
- R10: Sleep with the enable clear and a request already pending does not raise halted. fetchRepeat goes high the cycle after that completion and stays high until the next completion.
- R11: While halted, completion and decode strobes are ignored. A disable strobe then leaves imeFlag unchanged.
- R12: Sleep with the enable set and a request already pending starts service at once and never raises halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instrDone | input | 1 | An instruction retires this cycle |
| diStb | input | 1 | Retiring instruction is disable-interrupts |
| eiStb | input | 1 | Retiring instruction is enable-interrupts |
| retiStb | input | 1 | Retiring instruction is return-from-handler |
| haltStb | input | 1 | Retiring instruction is sleep |
| ieReg | input | NUM_IRQ | Interrupt enable mask |
| ifReg | input | NUM_IRQ | Interrupt request flags |
| imeFlag | output | 1 | Global interrupt enable |
| halted | output | 1 | Core is sleeping (low-power indicator) |
| fetchRepeat | output | 1 | Next opcode fetch must not advance the program counter |
| svcStart | output | 1 | One-cycle pulse: enter interrupt handler |
| svcAck | output | NUM_IRQ | One-hot request bit to clear, valid with svcStart |
| svcVector | output | ADDR_W | Handler address, valid with svcStart |

## Verification
The repeated-fetch outcome is the hardest case to reach. It needs the enable clear and a request already pending at the moment the sleep instruction retires, so the bench first services a request or lets one go idle and then raises an enabled flag before issuing the sleep. Just as delicate is the delayed enable, which is reached by a retiring enable immediately followed by a disable, and separately by an enable retiring while a request is already pending. In that second case the request must be serviced one completion later and not at the enable itself. Waking from sleep is also driven with request flags that are set but masked, to show that masked flags do not end the sleep.

// File: rtl/ime_pkg.sv
package ime_pkg;
  // Strobes from the control FSM to the selection datapath
  typedef struct packed {
    logic svcGo;   // begin interrupt service this cycle
  } ctlStrb_t;
endpackage

// File: rtl/ime_ctrl.sv
module ime_ctrl (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instrDone,
  input  logic             diStb,
  input  logic             eiStb,
  input  logic             retiStb,
  input  logic             haltStb,
  input  logic             pendAny,
  output logic             imeFlag,
  output logic             halted,
  output logic             fetchRepeat,
  output ime_pkg::ctlStrb_t strb
);
  logic eiArm;
  logic boundary;
  logic imeNext;
  logic takeNow;
  logic takeWake;

  always_comb begin
    boundary = instrDone && !halted;
    if (diStb)                  imeNext = 1'b0;
    else if (retiStb || eiArm)  imeNext = 1'b1;
    else                        imeNext = imeFlag;
    takeNow   = boundary && imeNext && pendAny;
    takeWake  = halted && imeFlag && pendAny;
    strb.svcGo = takeNow || takeWake;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imeFlag     <= 1'b0;
      eiArm       <= 1'b0;
      halted      <= 1'b0;
      fetchRepeat <= 1'b0;
    end else if (halted) begin
      if (pendAny) begin
        halted <= 1'b0;
        if (imeFlag) imeFlag <= 1'b0;
      end
    end else if (boundary) begin
      imeFlag     <= takeNow ? 1'b0 : imeNext;
      eiArm       <= eiStb;
      halted      <= haltStb && !pendAny;
      fetchRepeat <= haltStb && !imeNext && pendAny;
    end
  end

  // R5
  ime_clr_on_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.svcGo |=> !imeFlag);
  // R8
  halt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && pendAny) |=> !halted);
  // R10
  repeat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetchRepeat) |-> $past(instrDone && haltStb));
  // R3
  ime_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(imeFlag) |-> $past(boundary && (retiStb || eiArm)));
  // R12
  no_sleep_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    takeNow |=> !halted);
endmodule

// File: rtl/irq_sel.sv
module irq_sel #(
  parameter int NUM_IRQ  = 5,
  parameter int ADDR_W   = 16,
  parameter int VEC_BASE = 'h40,
  parameter int VEC_STEP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IRQ-1:0] ieReg,
  input  logic [NUM_IRQ-1:0] ifReg,
  input  ime_pkg::ctlStrb_t  strb,
  output logic              pendAny,
  output logic              svcStart,
  output logic [NUM_IRQ-1:0] svcAck,
  output logic [ADDR_W-1:0]  svcVector
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [NUM_IRQ-1:0] pend;
  logic [IDX_W-1:0]   selIdx;
  logic [NUM_IRQ-1:0] selOneHot;
  logic [ADDR_W-1:0]  vecCalc;

  always_comb begin
    pend    = ieReg & ifReg;
    pendAny = |pend;
    selIdx  = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (pend[i]) selIdx = IDX_W'(i);
    end
    selOneHot = NUM_IRQ'(1) << selIdx;
    vecCalc   = ADDR_W'(VEC_BASE) + ADDR_W'(selIdx) * ADDR_W'(VEC_STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svcStart  <= 1'b0;
      svcAck    <= '0;
      svcVector <= '0;
    end else begin
      svcStart <= strb.svcGo;
      svcAck   <= strb.svcGo ? selOneHot : '0;
      if (strb.svcGo) svcVector <= vecCalc;
    end
  end

  // R6
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svcStart |-> ($countones(svcAck) == 1));
  // R6
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !svcStart |-> (svcAck == '0));
  // R6
  ack_was_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svcStart |-> (($past(pend) & svcAck) == svcAck));
endmodule

// File: rtl/irq_sleep_ctrl.sv
module irq_sleep_ctrl #(
  parameter int NUM_IRQ  = 5,
  parameter int ADDR_W   = 16,
  parameter int VEC_BASE = 'h40,
  parameter int VEC_STEP = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instrDone,
  input  logic               diStb,
  input  logic               eiStb,
  input  logic               retiStb,
  input  logic               haltStb,
  input  logic [NUM_IRQ-1:0] ieReg,
  input  logic [NUM_IRQ-1:0] ifReg,
  output logic               imeFlag,
  output logic               halted,
  output logic               fetchRepeat,
  output logic               svcStart,
  output logic [NUM_IRQ-1:0] svcAck,
  output logic [ADDR_W-1:0]  svcVector
);
  ime_pkg::ctlStrb_t strb;
  logic pendAny;

  ime_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .instrDone(instrDone),
    .diStb(diStb), .eiStb(eiStb), .retiStb(retiStb), .haltStb(haltStb),
    .pendAny(pendAny), .imeFlag(imeFlag), .halted(halted),
    .fetchRepeat(fetchRepeat), .strb(strb)
  );

  irq_sel #(
    .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_sel (
    .clk(clk), .rst_n(rst_n), .ieReg(ieReg), .ifReg(ifReg), .strb(strb),
    .pendAny(pendAny), .svcStart(svcStart), .svcAck(svcAck), .svcVector(svcVector)
  );
endmodule

// File: tb/irq_sleep_ctrl_bench.sv
module irq_sleep_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instrDone = 1'b0, diStb = 1'b0, eiStb = 1'b0, retiStb = 1'b0, haltStb = 1'b0;
  logic [4:0] ieReg = '0, ifReg = '0;
  logic imeFlag, halted, fetchRepeat, svcStart;
  logic [4:0] svcAck;
  logic [15:0] svcVector;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  irq_sleep_ctrl u_irq_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .instrDone(instrDone), .diStb(diStb), .eiStb(eiStb),
    .retiStb(retiStb), .haltStb(haltStb), .ieReg(ieReg), .ifReg(ifReg),
    .imeFlag(imeFlag), .halted(halted), .fetchRepeat(fetchRepeat),
    .svcStart(svcStart), .svcAck(svcAck), .svcVector(svcVector)
  );

  // {ie, if, expTake, expAck, expVec}
  localparam logic [31:0] VEC_TBL [8] = '{
    {5'h1F, 5'h01, 1'b1, 5'h01, 16'h0040},
    {5'h1F, 5'h02, 1'b1, 5'h02, 16'h0048},
    {5'h1F, 5'h14, 1'b1, 5'h04, 16'h0050},
    {5'h1F, 5'h18, 1'b1, 5'h08, 16'h0058},
    {5'h10, 5'h1F, 1'b1, 5'h10, 16'h0060},
    {5'h0A, 5'h0E, 1'b1, 5'h02, 16'h0048},
    {5'h05, 5'h0A, 1'b0, 5'h00, 16'h0000},
    {5'h1F, 5'h1F, 1'b1, 5'h01, 16'h0040}
  };

  task automatic chkEq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one retiring instruction: strobes held across one rising edge
  task automatic retire(bit di, bit ei, bit reti, bit ht);
    @(negedge clk);
    instrDone = 1'b1; diStb = di; eiStb = ei; retiStb = reti; haltStb = ht;
    @(negedge clk);
    instrDone = 1'b0; diStb = 1'b0; eiStb = 1'b0; retiStb = 1'b0; haltStb = 1'b0;
  endtask

  task automatic setIrq(logic [4:0] ie, logic [4:0] fl);
    @(negedge clk);
    ieReg = ie; ifReg = fl;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chkEq("R1 imeFlag", imeFlag, 0);
    chkEq("R1 halted", halted, 0);
    chkEq("R1 fetchRepeat", fetchRepeat, 0);
    chkEq("R1 svcStart", svcStart, 0);

    // R5 R6 R7: table walk
    for (int k = 0; k < 8; k++) begin
      setIrq(5'h00, 5'h00);
      retire(0, 0, 1, 0);
      setIrq(VEC_TBL[k][31:27], VEC_TBL[k][26:22]);
      retire(0, 0, 0, 0);
      chkEq("R5/R7 svcStart", svcStart, VEC_TBL[k][21]);
      chkEq("R5 imeFlag", imeFlag, !VEC_TBL[k][21]);
      chkEq("R6 svcAck", svcAck, VEC_TBL[k][20:16]);
      if (VEC_TBL[k][21]) chkEq("R6 svcVector", svcVector, VEC_TBL[k][15:0]);
      retire(1, 0, 0, 0);
    end

    // R3: delayed enable
    setIrq(5'h00, 5'h00);
    retire(1, 0, 0, 0);
    retire(0, 1, 0, 0);
    chkEq("R3 ime after EI", imeFlag, 0);
    retire(0, 0, 0, 0);
    chkEq("R3 ime after next", imeFlag, 1);
    retire(1, 0, 0, 0);
    chkEq("R2 ime after DI", imeFlag, 0);
    retire(0, 1, 0, 0);
    retire(1, 0, 0, 0);
    chkEq("R3 EI then DI", imeFlag, 0);
    retire(0, 0, 0, 0);
    chkEq("R3 EI cancelled", imeFlag, 0);
    setIrq(5'h01, 5'h01);
    retire(0, 1, 0, 0);
    chkEq("R3 no svc at EI", svcStart, 0);
    retire(0, 0, 0, 0);
    chkEq("R3 svc after next", svcStart, 1);
    chkEq("R3 vector", svcVector, 16'h0040);
    chkEq("R3 ime cleared", imeFlag, 0);

    // R2 R7 R4
    setIrq(5'h00, 5'h00);
    retire(0, 0, 1, 0);
    chkEq("R4 ime at RETI", imeFlag, 1);
    setIrq(5'h10, 5'h10);
    retire(1, 0, 0, 0);
    chkEq("R2 no svc at DI", svcStart, 0);
    chkEq("R2 ime", imeFlag, 0);
    retire(0, 0, 0, 0);
    chkEq("R7 no svc ime clear", svcStart, 0);
    retire(0, 0, 1, 0);
    chkEq("R4 svc at RETI", svcStart, 1);
    chkEq("R4 vector", svcVector, 16'h0060);

    // R8 R11
    setIrq(5'h00, 5'h00);
    retire(0, 0, 1, 0);
    retire(0, 0, 0, 1);
    chkEq("R8 halted", halted, 1);
    chkEq("R8 no svc", svcStart, 0);
    repeat (3) @(negedge clk);
    chkEq("R8 still halted", halted, 1);
    retire(1, 0, 0, 0);
    chkEq("R11 ime kept", imeFlag, 1);
    chkEq("R11 halted kept", halted, 1);
    setIrq(5'h1F, 5'h04);
    @(negedge clk);
    chkEq("R8 wake svc", svcStart, 1);
    chkEq("R8 vector", svcVector, 16'h0050);
    chkEq("R8 halted clr", halted, 0);
    chkEq("R8 ime clr", imeFlag, 0);

    // R9
    setIrq(5'h00, 5'h00);
    retire(0, 0, 0, 1);
    chkEq("R9 halted", halted, 1);
    setIrq(5'h00, 5'h08);
    @(negedge clk);
    chkEq("R9 masked flag no wake", halted, 1);
    setIrq(5'h08, 5'h08);
    @(negedge clk);
    chkEq("R9 woke", halted, 0);
    chkEq("R9 no svc", svcStart, 0);
    chkEq("R9 ime", imeFlag, 0);

    // R10
    retire(0, 0, 0, 1);
    chkEq("R10 not halted", halted, 0);
    chkEq("R10 repeat", fetchRepeat, 1);
    chkEq("R10 no svc", svcStart, 0);
    @(negedge clk);
    chkEq("R10 repeat held", fetchRepeat, 1);
    retire(0, 0, 0, 0);
    chkEq("R10 repeat clr", fetchRepeat, 0);

    // R12
    setIrq(5'h00, 5'h00);
    retire(0, 0, 1, 0);
    setIrq(5'h02, 5'h02);
    retire(0, 0, 0, 1);
    chkEq("R12 svc", svcStart, 1);
    chkEq("R12 vector", svcVector, 16'h0048);
    chkEq("R12 halted", halted, 0);
    chkEq("R12 repeat", fetchRepeat, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule